// File: doc/BRIEF.md
# Programmable IO sequencer core

This block is a small instruction sequencer for bit-banged pin protocols. A host loads up to 32 sixteen-bit instructions into a local instruction memory through a write port, then pulses a restart. From then on the sequencer fetches the instruction at its program counter on every cycle in which an external divider's clock-enable tick is high. It executes jumps on scratch-register and pin conditions, waits on input levels, writes immediates into pins, pin directions or the two scratch registers, and moves data between the scratch registers. Shift registers, FIFOs and interrupt flags live outside the block. Only the output-shift-register status enters, as a plain input.

Every instruction carries a five-bit field that is shared between a side-set value and a delay count. How the field is split depends on the configured side-set width and on an optional enable bit. The program counter does not run linearly: it wraps from a programmable top address back to a programmable bottom address. Pin groups are addressed from a configured base pin and wrap past the highest pin.

The control is a two-state machine. RUN executes the fetched instruction. DELAY burns the delay cycles of the instruction that just completed. The transitions are: RUN stays in RUN when the instruction stalls or completes with a zero delay (named HOLD and STEP). RUN goes to DELAY when it completes with a nonzero delay (named ENTER_DELAY). DELAY stays in DELAY while more than one delay cycle is left (named COUNT). DELAY returns to RUN on its last cycle (named RESUME). Both states return to RUN on a restart (named RESTART).

Top module: `pioseq_core`

## Requirements
- R1: After reset, pc, pin_out and pin_dir are all zero, and every memory word is 0x0000, which is an unconditional jump to address 0, so ticking leaves pc at 0.
- R2: On a cycle with tick low and restart low, pc, pin_out, pin_dir and all internal state hold their values.
- R3: Opcode 0 (bits 15:13) is a jump to bits 4:0 under the condition in bits 7:5. The conditions are 0 always, 1 X zero, 2 X nonzero (X decrements either way), 3 Y zero, 4 Y nonzero (Y decrements either way), 5 X differs from Y, 6 gpio_in[jmp_pin_sel] high, 7 osr_not_empty high.
- R4: Opcode 7 writes the zero-extended 5-bit immediate in bits 4:0 to the target in bits 7:5: 0 the pins, 1 X, 2 Y, 4 the directions. The pins and directions affected are set_count (at most 5) consecutive pins from set_base, wrapping past the highest pin, with immediate bit 0 on the base pin.
- R5: Bits 12:8 form the side-set/delay field. With ss_count=N and ss_opt=O, the top O bits are an enable flag, the next N bits are the side-set value, and the remaining low bits are the delay. The side-set value goes to N pins from ss_base (to the directions when ss_pindir is 1) on every RUN tick, also while the instruction stalls, and it wins over an immediate write to the same pin. With O=1 and the flag clear, no side-set happens.
- R6: An instruction with delay D completes on its first non-stalled tick, updating pc then. The next instruction executes on the (D+1)-th tick after it.
- R7: When no jump is taken and pc equals wrap_top, the next pc is wrap_bottom. Otherwise it is pc+1 modulo 32, or the jump target when a jump is taken.
- R8: Opcode 1 stalls the program counter until the selected input equals the polarity in bit 7. Bits 6:5 select the source: 0 is gpio_in[index], 1 is gpio_in[in_base+index] (wrapping), and any other value is not waited on. The index is in bits 4:0.
- R9: A restart, independent of tick, loads pc from start_pc, clears X, Y and any pending delay, and returns to RUN on the next edge.
- R10: Opcode 5 moves a source (bits 2:0: 0 mapped input pins, 1 X, 2 Y, 3 zero) to a destination (bits 7:5: 1 X, 2 Y) under the operation in bits 4:3 (0 copy, 1 bitwise invert, 2 bit reverse).
- R11: Opcodes 2, 3, 4 and 6 change nothing but the program counter, which advances like a step that takes no jump.
- R12: The host write port stores imem_wdata at imem_waddr on any clock edge with imem_we high, whatever the tick, and the stored word is executed when pc reaches that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable from the external divider |
| restart | input | 1 | Synchronous restart |
| start_pc | input | 5 | Address loaded on restart |
| wrap_top | input | 5 | Address after which the pc wraps |
| wrap_bottom | input | 5 | Address the pc wraps to |
| ss_count | input | 3 | Number of side-set value bits |
| ss_opt | input | 1 | Side-set carries an enable flag |
| ss_pindir | input | 1 | Side-set drives directions instead of values |
| ss_base | input | 5 | First side-set pin |
| set_base | input | 5 | First pin of the immediate-write group |
| set_count | input | 3 | Width of the immediate-write group |
| in_base | input | 5 | First pin of the mapped input group |
| jmp_pin_sel | input | 5 | Pin tested by jump condition 6 |
| gpio_in | input | 32 | Input pin levels |
| osr_not_empty | input | 1 | Output shift register status from outside |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | 5 | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to store |
| pin_out | output | 32 | Pin output values |
| pin_dir | output | 32 | Pin directions, 1 = output |
| pc | output | 5 | Current program counter |

## Verification
Every architectural result appears one clock edge after a ticked edge. The pc, pins and directions move at the edge where tick is high, and a restart acts at its own edge. A delay of D pushes the next visible effect D ticked edges further out. The bench changes inputs on the falling edge, counts the exact number of ticked rising edges each instruction needs, and samples on the following falling edge, where the registered outputs have settled. The scratch registers have no port, so their values are read back through jump outcomes on pc.

// File: rtl/pioseq_pkg.sv
package pioseq_pkg;

    localparam int INSTR_W = 16;
    localparam int ADDR_W  = 5;
    localparam int FIELD_W = 5;

    typedef enum logic [2:0] {
        OP_JMP   = 3'd0,
        OP_WAIT  = 3'd1,
        OP_IN    = 3'd2,
        OP_OUT   = 3'd3,
        OP_XFER  = 3'd4,
        OP_MOV   = 3'd5,
        OP_IRQ   = 3'd6,
        OP_SET   = 3'd7
    } opcode_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DELAY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pioseq_imem.sv
module pioseq_imem #(
    parameter int AW = 5,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pioseq_fieldsplit.sv
module pioseq_fieldsplit #(
    parameter int FW = 5
) (
    input  logic [FW-1:0] field,
    input  logic [2:0]    ss_count,
    input  logic          ss_opt,
    output logic          ss_en,
    output logic [FW-1:0] ss_val,
    output logic [2:0]    ss_width,
    output logic [FW-1:0] delay
);
    int          opt_bits;
    int          val_bits;
    int          dly_bits;
    logic [FW:0] dly_mask;
    logic [FW:0] val_mask;
    logic [FW-1:0] upper;

    always_comb begin
        opt_bits = ss_opt ? 1 : 0;
        val_bits = int'(ss_count);
        if (val_bits + opt_bits > FW) begin
            val_bits = FW - opt_bits;
        end
        dly_bits = FW - val_bits - opt_bits;
        dly_mask = (FW+1)'((1 << dly_bits) - 1);
        val_mask = (FW+1)'((1 << val_bits) - 1);
        upper    = field >> dly_bits;
        delay    = field & dly_mask[FW-1:0];
        ss_val   = upper & val_mask[FW-1:0];
        ss_width = 3'(val_bits);
        ss_en    = (val_bits != 0) && (!ss_opt || field[FW-1]);
    end

endmodule

// File: rtl/pioseq_pinmap.sv
module pioseq_pinmap #(
    parameter int NUM_PINS = 32,
    parameter int PW       = 5
) (
    input  logic [NUM_PINS-1:0] cur,
    input  logic                en,
    input  logic [PW-1:0]       base,
    input  logic [2:0]          count,
    input  logic [4:0]          value,
    output logic [NUM_PINS-1:0] nxt
);
    logic [7:0] vpad;
    assign vpad = {3'b000, value};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        int offs;
        always_comb begin
            if (p >= int'(base)) begin
                offs = p - int'(base);
            end else begin
                offs = p + NUM_PINS - int'(base);
            end
            if (en && (offs < int'(count))) begin
                nxt[p] = vpad[offs[2:0]];
            end else begin
                nxt[p] = cur[p];
            end
        end
    end

endmodule

// File: rtl/pioseq_core.sv
module pioseq_core
    import pioseq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int XW       = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        restart,
    input  logic [ADDR_W-1:0]           start_pc,
    input  logic [ADDR_W-1:0]           wrap_top,
    input  logic [ADDR_W-1:0]           wrap_bottom,
    input  logic [2:0]                  ss_count,
    input  logic                        ss_opt,
    input  logic                        ss_pindir,
    input  logic [$clog2(NUM_PINS)-1:0] ss_base,
    input  logic [$clog2(NUM_PINS)-1:0] set_base,
    input  logic [2:0]                  set_count,
    input  logic [$clog2(NUM_PINS)-1:0] in_base,
    input  logic [$clog2(NUM_PINS)-1:0] jmp_pin_sel,
    input  logic [NUM_PINS-1:0]         gpio_in,
    input  logic                        osr_not_empty,
    input  logic                        imem_we,
    input  logic [ADDR_W-1:0]           imem_waddr,
    input  logic [INSTR_W-1:0]          imem_wdata,
    output logic [NUM_PINS-1:0]         pin_out,
    output logic [NUM_PINS-1:0]         pin_dir,
    output logic [ADDR_W-1:0]           pc
);
    localparam int PW = $clog2(NUM_PINS);

    // Architectural state
    seq_state_e          state_q, state_nx;
    logic [ADDR_W-1:0]   pc_q;
    logic [XW-1:0]       x_q, y_q;
    logic [FIELD_W-1:0]  dcnt_q;
    logic [NUM_PINS-1:0] pout_q, pdir_q;

    // Fetch and field decode
    logic [INSTR_W-1:0]  instr;
    opcode_e             op;
    logic [2:0]          arg_hi;
    logic [4:0]          arg_lo;
    logic                ss_en;
    logic [FIELD_W-1:0]  ss_val;
    logic [2:0]          ss_width;
    logic [FIELD_W-1:0]  dly;

    pioseq_imem #(.AW(ADDR_W), .IW(INSTR_W)) u_imem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (pc_q),
        .rdata (instr)
    );

    assign op     = opcode_e'(instr[15:13]);
    assign arg_hi = instr[7:5];
    assign arg_lo = instr[4:0];

    pioseq_fieldsplit #(.FW(FIELD_W)) u_split (
        .field    (instr[12:8]),
        .ss_count (ss_count),
        .ss_opt   (ss_opt),
        .ss_en    (ss_en),
        .ss_val   (ss_val),
        .ss_width (ss_width),
        .delay    (dly)
    );

    // Execute
    logic                stall;
    logic                jmp_taken;
    logic                set_pins_en, set_dirs_en;
    logic [XW-1:0]       x_nx, y_nx;
    logic [XW-1:0]       in_word, mov_src, mov_val;
    logic [PW-1:0]       wait_idx;
    logic                wait_lvl;
    logic [2:0]          set_cnt_eff;
    logic [ADDR_W-1:0]   pc_step, pc_nx;

    always_comb begin
        for (int i = 0; i < XW; i++) begin
            in_word[i] = gpio_in[PW'((int'(in_base) + i) % NUM_PINS)];
        end
    end

    always_comb begin
        unique case (instr[2:0])
            3'd0:    mov_src = in_word;
            3'd1:    mov_src = x_q;
            3'd2:    mov_src = y_q;
            default: mov_src = '0;
        endcase
        unique case (instr[4:3])
            2'd1:    mov_val = ~mov_src;
            2'd2: begin
                for (int i = 0; i < XW; i++) begin
                    mov_val[i] = mov_src[XW-1-i];
                end
            end
            default: mov_val = mov_src;
        endcase
    end

    always_comb begin
        stall       = 1'b0;
        jmp_taken   = 1'b0;
        set_pins_en = 1'b0;
        set_dirs_en = 1'b0;
        x_nx        = x_q;
        y_nx        = y_q;
        wait_idx    = '0;
        wait_lvl    = 1'b0;
        case (op)
            OP_JMP: begin
                unique case (arg_hi)
                    3'd0: jmp_taken = 1'b1;
                    3'd1: jmp_taken = (x_q == '0);
                    3'd2: begin
                        jmp_taken = (x_q != '0);
                        x_nx      = x_q - XW'(1);
                    end
                    3'd3: jmp_taken = (y_q == '0);
                    3'd4: begin
                        jmp_taken = (y_q != '0);
                        y_nx      = y_q - XW'(1);
                    end
                    3'd5: jmp_taken = (x_q != y_q);
                    3'd6: jmp_taken = gpio_in[jmp_pin_sel];
                    3'd7: jmp_taken = osr_not_empty;
                endcase
            end
            OP_WAIT: begin
                unique case (instr[6:5])
                    2'd0: begin
                        wait_idx = PW'(int'(arg_lo) % NUM_PINS);
                        wait_lvl = gpio_in[wait_idx];
                        stall    = (wait_lvl != instr[7]);
                    end
                    2'd1: begin
                        wait_idx = PW'((int'(in_base) + int'(arg_lo)) % NUM_PINS);
                        wait_lvl = gpio_in[wait_idx];
                        stall    = (wait_lvl != instr[7]);
                    end
                    default: stall = 1'b0;
                endcase
            end
            OP_SET: begin
                unique case (arg_hi)
                    3'd0:    set_pins_en = 1'b1;
                    3'd1:    x_nx = XW'(arg_lo);
                    3'd2:    y_nx = XW'(arg_lo);
                    3'd4:    set_dirs_en = 1'b1;
                    default: ;
                endcase
            end
            OP_MOV: begin
                unique case (arg_hi)
                    3'd1:    x_nx = mov_val;
                    3'd2:    y_nx = mov_val;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // Next program counter: jump, wrap, or step
    assign pc_step = (pc_q == wrap_top) ? wrap_bottom : pc_q + ADDR_W'(1);
    assign pc_nx   = jmp_taken ? arg_lo : pc_step;

    // Pin and direction updates: immediate write first, side-set on top
    logic [NUM_PINS-1:0] pout_set, pdir_set, pout_nx, pdir_nx;

    assign set_cnt_eff = (set_count > 3'd5) ? 3'd5 : set_count;

    pioseq_pinmap #(.NUM_PINS(NUM_PINS), .PW(PW)) u_map_set_out (
        .cur (pout_q), .en (set_pins_en), .base (set_base),
        .count (set_cnt_eff), .value (arg_lo), .nxt (pout_set)
    );

    pioseq_pinmap #(.NUM_PINS(NUM_PINS), .PW(PW)) u_map_set_dir (
        .cur (pdir_q), .en (set_dirs_en), .base (set_base),
        .count (set_cnt_eff), .value (arg_lo), .nxt (pdir_set)
    );

    pioseq_pinmap #(.NUM_PINS(NUM_PINS), .PW(PW)) u_map_ss_out (
        .cur (pout_set), .en (ss_en && !ss_pindir), .base (ss_base),
        .count (ss_width), .value (ss_val), .nxt (pout_nx)
    );

    pioseq_pinmap #(.NUM_PINS(NUM_PINS), .PW(PW)) u_map_ss_dir (
        .cur (pdir_set), .en (ss_en && ss_pindir), .base (ss_base),
        .count (ss_width), .value (ss_val), .nxt (pdir_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else if (restart) begin
            state_q <= ST_RUN;
        end else if (tick) begin
            state_q <= state_nx;
        end
    end

    // Transitions: HOLD / STEP / ENTER_DELAY from RUN, COUNT / RESUME from DELAY
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!stall && (dly != '0)) begin
                    state_nx = ST_DELAY;
                end else begin
                    state_nx = ST_RUN;
                end
            end
            ST_DELAY: begin
                if (dcnt_q == FIELD_W'(1)) begin
                    state_nx = ST_RUN;
                end else begin
                    state_nx = ST_DELAY;
                end
            end
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            dcnt_q <= '0;
            pout_q <= '0;
            pdir_q <= '0;
        end else if (restart) begin
            pc_q   <= start_pc;
            x_q    <= '0;
            y_q    <= '0;
            dcnt_q <= '0;
        end else if (tick) begin
            unique case (state_q)
                ST_RUN: begin
                    pout_q <= pout_nx;
                    pdir_q <= pdir_nx;
                    if (!stall) begin
                        pc_q   <= pc_nx;
                        x_q    <= x_nx;
                        y_q    <= y_nx;
                        dcnt_q <= dly;
                    end
                end
                ST_DELAY: begin
                    dcnt_q <= dcnt_q - FIELD_W'(1);
                end
            endcase
        end
    end

    assign pc      = pc_q;
    assign pin_out = pout_q;
    assign pin_dir = pdir_q;

endmodule

// File: rtl/pioseq_core_chk.sv
module pioseq_core_chk
    import pioseq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                restart,
    input logic [ADDR_W-1:0]   start_pc,
    input logic [ADDR_W-1:0]   wrap_top,
    input logic [ADDR_W-1:0]   wrap_bottom,
    input logic [ADDR_W-1:0]   pc,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_dir,
    input seq_state_e          state_q,
    input logic                stall,
    input logic                jmp_taken
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(pc) && $stable(pin_out) && $stable(pin_dir))); // R2

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pc == $past(start_pc))); // R9

    AST_DELAY_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && !restart) |=> $stable(pc)); // R6

    AST_STALL_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && state_q == ST_RUN && stall) |=> $stable(pc)); // R8

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && state_q == ST_RUN && !stall && !jmp_taken && pc == wrap_top)
        |=> (pc == $past(wrap_bottom))); // R7

endmodule

bind pioseq_core pioseq_core_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .restart     (restart),
    .start_pc    (start_pc),
    .wrap_top    (wrap_top),
    .wrap_bottom (wrap_bottom),
    .pc          (pc),
    .pin_out     (pin_out),
    .pin_dir     (pin_dir),
    .state_q     (state_q),
    .stall       (stall),
    .jmp_taken   (jmp_taken)
);

// File: tb/pioseq_core_tb.sv
module pioseq_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        restart = 1'b0;
    logic [4:0]  start_pc = '0;
    logic [4:0]  wrap_top = 5'd31;
    logic [4:0]  wrap_bottom = '0;
    logic [2:0]  ss_count = '0;
    logic        ss_opt = 1'b0;
    logic        ss_pindir = 1'b0;
    logic [4:0]  ss_base = '0;
    logic [4:0]  set_base = '0;
    logic [2:0]  set_count = 3'd5;
    logic [4:0]  in_base = '0;
    logic [4:0]  jmp_pin_sel = '0;
    logic [31:0] gpio_in = '0;
    logic        osr_not_empty = 1'b0;
    logic        imem_we = 1'b0;
    logic [4:0]  imem_waddr = '0;
    logic [15:0] imem_wdata = '0;
    logic [31:0] pin_out, pin_dir;
    logic [4:0]  pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pioseq_core u_dut (
        .clk (clk), .rst_n (rst_n), .tick (tick), .restart (restart),
        .start_pc (start_pc), .wrap_top (wrap_top), .wrap_bottom (wrap_bottom),
        .ss_count (ss_count), .ss_opt (ss_opt), .ss_pindir (ss_pindir),
        .ss_base (ss_base), .set_base (set_base), .set_count (set_count),
        .in_base (in_base), .jmp_pin_sel (jmp_pin_sel), .gpio_in (gpio_in),
        .osr_not_empty (osr_not_empty), .imem_we (imem_we),
        .imem_waddr (imem_waddr), .imem_wdata (imem_wdata),
        .pin_out (pin_out), .pin_dir (pin_dir), .pc (pc)
    );

    // Instruction encoders
    function automatic logic [15:0] e_set(logic [2:0] d, logic [4:0] v, logic [4:0] f);
        return {3'b111, f, d, v};
    endfunction
    function automatic logic [15:0] e_jmp(logic [2:0] c, logic [4:0] a, logic [4:0] f);
        return {3'b000, f, c, a};
    endfunction
    function automatic logic [15:0] e_wait(logic p, logic [1:0] s, logic [4:0] i, logic [4:0] f);
        return {3'b001, f, p, s, i};
    endfunction
    function automatic logic [15:0] e_mov(logic [2:0] d, logic [1:0] o, logic [2:0] s, logic [4:0] f);
        return {3'b101, f, d, o, s};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        imem_we = 1'b1; imem_waddr = a; imem_wdata = d;
        @(posedge clk); @(negedge clk);
        imem_we = 1'b0;
    endtask

    task automatic do_restart(logic [4:0] spc);
        start_pc = spc; restart = 1'b1;
        @(posedge clk); @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic ticks(int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic prog4(logic [15:0] i0, logic [15:0] i1, logic [15:0] i2, logic [15:0] i3);
        wr(5'd0, i0); wr(5'd1, i1); wr(5'd2, i2); wr(5'd3, i3);
        do_restart(5'd0);
    endtask

    // Table row: {gpio_in[9], expected pc, expected pin_out[4:0]} after one tick
    localparam logic [10:0] VEC [16] = '{
        {1'b0, 5'd1, 5'h15}, {1'b0, 5'd2, 5'h05}, {1'b0, 5'd2, 5'h15}, {1'b0, 5'd2, 5'h15},
        {1'b1, 5'd3, 5'h15}, {1'b0, 5'd3, 5'h05}, {1'b0, 5'd3, 5'h05}, {1'b0, 5'd3, 5'h05},
        {1'b0, 5'd3, 5'h05}, {1'b0, 5'd4, 5'h05}, {1'b0, 5'd4, 5'h05}, {1'b0, 5'd1, 5'h0A},
        {1'b0, 5'd1, 5'h0A}, {1'b0, 5'd1, 5'h0A}, {1'b0, 5'd2, 5'h0A}, {1'b0, 5'd2, 5'h1A}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap_out;
        logic [4:0]  snap_pc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and zeroed memory
        chk("R1 reset pc", 32'(pc), 32'd0);
        chk("R1 reset pin_out", pin_out, 32'd0);
        chk("R1 reset pin_dir", pin_dir, 32'd0);
        ticks(2);
        chk("R1 zero memory jumps to 0", 32'(pc), 32'd0);

        // Table program: one side-set bit on pin 4, 4-bit delay
        ss_count = 3'd1; ss_opt = 1'b0; ss_base = 5'd4;
        set_base = 5'd0; set_count = 3'd4; in_base = 5'd8;
        wrap_top = 5'd4; wrap_bottom = 5'd1;
        wr(5'd0, e_set(3'd0, 5'd5, 5'b10000));
        wr(5'd1, e_set(3'd1, 5'd2, 5'b00000));
        wr(5'd2, e_wait(1'b1, 2'd1, 5'd1, 5'b10000));
        wr(5'd3, e_jmp(3'd2, 5'd3, 5'b00001));
        wr(5'd4, e_set(3'd0, 5'd10, 5'b00010));
        chk("R12 writes with tick low leave pc", 32'(pc), 32'd0);
        do_restart(5'd0);
        for (int r = 0; r < 16; r++) begin
            gpio_in = 32'(VEC[r][10]) << 9;
            ticks(1);
            chk($sformatf("R5 R6 R7 R8 R12 table row %0d pc", r), 32'(pc), 32'(VEC[r][9:5]));
            chk($sformatf("R4 R5 table row %0d pins", r), 32'(pin_out[4:0]), 32'(VEC[r][4:0]));
        end
        gpio_in = '0;

        // Directed tests: no side-set, 5-bit delay, no wrap
        ss_count = 3'd0; set_count = 3'd5; wrap_top = 5'd31; wrap_bottom = 5'd0;

        // R3 jump conditions
        prog4(e_set(3'd1, 5'd0, 5'd0), e_jmp(3'd1, 5'd7, 5'd0), 16'h0, 16'h0);
        ticks(2); chk("R3 X zero taken", 32'(pc), 32'd7);
        prog4(e_set(3'd1, 5'd3, 5'd0), e_jmp(3'd1, 5'd7, 5'd0), 16'h0, 16'h0);
        ticks(2); chk("R3 X zero not taken", 32'(pc), 32'd2);
        prog4(e_set(3'd2, 5'd1, 5'd0), e_jmp(3'd4, 5'd7, 5'd0), 16'h0, 16'h0);
        ticks(2); chk("R3 Y nonzero taken", 32'(pc), 32'd7);
        prog4(e_set(3'd2, 5'd0, 5'd0), e_jmp(3'd4, 5'd7, 5'd0), e_jmp(3'd3, 5'd9, 5'd0), 16'h0);
        ticks(3); chk("R3 Y post-decrement wraps", 32'(pc), 32'd3);
        prog4(e_set(3'd1, 5'd1, 5'd0), e_set(3'd2, 5'd1, 5'd0), e_jmp(3'd5, 5'd9, 5'd0), 16'h0);
        ticks(3); chk("R3 X equal Y", 32'(pc), 32'd3);
        prog4(e_set(3'd1, 5'd1, 5'd0), e_set(3'd2, 5'd2, 5'd0), e_jmp(3'd5, 5'd9, 5'd0), 16'h0);
        ticks(3); chk("R3 X differs Y", 32'(pc), 32'd9);
        jmp_pin_sel = 5'd10; gpio_in = 32'h0000_0400;
        prog4(e_jmp(3'd6, 5'd12, 5'd0), 16'h0, 16'h0, 16'h0);
        ticks(1); chk("R3 jump pin high", 32'(pc), 32'd12);
        gpio_in = '0;
        prog4(e_jmp(3'd6, 5'd12, 5'd0), 16'h0, 16'h0, 16'h0);
        ticks(1); chk("R3 jump pin low", 32'(pc), 32'd1);
        osr_not_empty = 1'b1;
        prog4(e_jmp(3'd7, 5'd12, 5'd0), 16'h0, 16'h0, 16'h0);
        ticks(1); chk("R3 osr status", 32'(pc), 32'd12);
        osr_not_empty = 1'b0;

        // R10 moves
        prog4(e_set(3'd2, 5'd6, 5'd0), e_mov(3'd1, 2'd0, 3'd2, 5'd0), e_jmp(3'd5, 5'd9, 5'd0), 16'h0);
        ticks(3); chk("R10 copy Y to X", 32'(pc), 32'd3);
        prog4(e_set(3'd1, 5'd0, 5'd0), e_mov(3'd2, 2'd1, 3'd1, 5'd0), e_jmp(3'd3, 5'd9, 5'd0), 16'h0);
        ticks(3); chk("R10 invert X to Y", 32'(pc), 32'd3);
        prog4(e_set(3'd1, 5'd1, 5'd0), e_set(3'd2, 5'd1, 5'd0), e_mov(3'd2, 2'd2, 3'd1, 5'd0),
              e_jmp(3'd5, 5'd9, 5'd0));
        ticks(4); chk("R10 reverse X to Y", 32'(pc), 32'd9);

        // R4 immediate writes with wrapping pin group
        set_base = 5'd30; set_count = 3'd4;
        prog4(e_set(3'd4, 5'b01111, 5'd0), e_set(3'd0, 5'b00110, 5'd0), 16'h0, 16'h0);
        ticks(2);
        chk("R4 directions wrap", pin_dir, 32'hC000_0003);
        chk("R4 pins wrap", pin_out & 32'hC000_0003, 32'h8000_0001);
        set_base = 5'd0; set_count = 3'd5;

        // R5 optional side-set: flag, 2 value bits, 2 delay bits
        ss_opt = 1'b1; ss_count = 3'd2; ss_base = 5'd0;
        prog4(e_set(3'd0, 5'd0, 5'b00000), e_jmp(3'd0, 5'd2, 5'b01100), e_jmp(3'd0, 5'd3, 5'b11000), 16'h0);
        ticks(2); chk("R5 flag clear no side-set", 32'(pin_out[4:0]), 32'h00);
        ticks(1); chk("R5 flag set side-set", 32'(pin_out[4:0]), 32'h02);
        ss_pindir = 1'b1; ss_base = 5'd2;
        prog4(e_jmp(3'd0, 5'd1, 5'b11000), 16'h0, 16'h0, 16'h0);
        ticks(1); chk("R5 side-set to directions", pin_dir, 32'hC000_000B);
        ss_pindir = 1'b0; ss_opt = 1'b0; ss_count = 3'd0;

        // R6 delay
        prog4(e_set(3'd0, 5'd1, 5'd3), e_set(3'd0, 5'd2, 5'd0), 16'h0, 16'h0);
        ticks(1);
        chk("R6 completes on first tick pc", 32'(pc), 32'd1);
        chk("R6 completes on first tick pins", 32'(pin_out[4:0]), 32'd1);
        ticks(3); chk("R6 next held during delay", 32'(pin_out[4:0]), 32'd1);
        ticks(1); chk("R6 next after delay", 32'(pin_out[4:0]), 32'd2);

        // R7 a taken jump at the top overrides the wrap
        wrap_top = 5'd1; wrap_bottom = 5'd0;
        prog4(e_jmp(3'd0, 5'd1, 5'd0), e_jmp(3'd0, 5'd5, 5'd0), 16'h0, 16'h0);
        ticks(2); chk("R7 jump beats wrap", 32'(pc), 32'd5);
        wrap_top = 5'd31;

        // R8 absolute GPIO wait, polarity low
        gpio_in = 32'h0000_0008;
        prog4(e_wait(1'b0, 2'd0, 5'd3, 5'd0), 16'h0, 16'h0, 16'h0);
        ticks(2); chk("R8 stalls while level differs", 32'(pc), 32'd0);
        gpio_in = '0;
        ticks(1); chk("R8 proceeds on match", 32'(pc), 32'd1);

        // R11 unsupported opcodes and a non-pin wait step only
        snap_out = pin_out;
        prog4(16'h4025, 16'h6025, 16'hC025, e_wait(1'b1, 2'd2, 5'd0, 5'd0));
        ticks(4);
        chk("R11 no-op opcodes advance pc", 32'(pc), 32'd4);
        chk("R11 no-op opcodes keep pins", pin_out, snap_out);

        // R9 restart mid-delay clears X and the delay
        prog4(e_set(3'd1, 5'd5, 5'd5), 16'h0, e_jmp(3'd1, 5'd20, 5'd0), 16'h0);
        ticks(2); chk("R9 in delay before restart", 32'(pc), 32'd1);
        do_restart(5'd2);
        chk("R9 loads start pc", 32'(pc), 32'd2);
        ticks(1); chk("R9 X cleared and no delay left", 32'(pc), 32'd20);

        // R2 tick low holds everything
        snap_pc = pc; snap_out = pin_out;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R2 pc held with tick low", 32'(pc), 32'(snap_pc));
        chk("R2 pins held with tick low", pin_out, snap_out);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule